// File: doc/BRIEF.md
# Two-Wire Block-Write Configuration Slave

This block is a serial configuration target on a two-wire bus (clock line plus bidirectional data line) running at standard mode, 100 kbit/s or slower. It holds a small bank of 8-bit configuration registers and presents all of them as parallel outputs. The two bus lines are sampled by the block's own system clock. The data line is driven open-drain style: the block drives an output enable, and the line is pulled low whenever that enable is high.

A write uses the 8-bit address byte 0xD2. The two bytes that follow it, a command byte and a count byte, are acknowledged and then thrown away. Every data byte after those goes into the next register, starting from register 0. The host may stop after any whole byte. A read uses 0xD3, which carries the same 7-bit address with the direction bit set. The block first answers with a byte count and then sends the registers in ascending order. Each access starts again from register 0.

Top module: `cfg_twowire_slave`

## Requirements
- R1: After reset the register outputs hold their defaults. With register k occupying bits [8k+7:8k] of `cfg_bytes`, the defaults are: byte 0 = 0x00, byte 1 = 0xFC, byte 2 = 0xF0, bytes 3 to 5 = 0x00, byte 6 = 0x06. `sda_oe` is 0.
- R2: The address byte is sent MSB first. 0xD2 (write) and 0xD3 (read) are acknowledged by driving SDA low in the ninth clock. Any other address gets no acknowledge, and the block stays silent until the next start.
- R3: In a write, the first two bytes after the address are acknowledged and have no effect on any register.
- R4: Data bytes of a write are each acknowledged and stored in order, the first into byte 0, then byte 1, and so on.
- R5: A stop after any complete data byte keeps every byte already received. Registers not reached keep their previous values.
- R6: A data byte beyond byte 6 is not acknowledged and is not stored.
- R7: A read at 0xD3 sends the count value 7 first, then bytes 0 through 6, each MSB first. The next byte follows whenever the host acknowledges.
- R8: Every start condition (SDA falling while SCL is high) resets the read position, so each read again begins with the count byte.
- R9: `sda_oe` only rises while SCL is low.
- R10: When the host does not acknowledge a read byte, the block releases SDA and drives nothing until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired line) |
| sda_oe | output | 1 | 1 pulls the data line low |
| cfg_bytes | output | 56 | Register bank, byte k at bits [8k+7:8k] |

## Verification
The hardest cases to reach are the edges of the byte stream. These are a write that runs past the last register, where the block must refuse a byte in the middle of a transaction, and a read cut short by a host not-acknowledge, followed by a new read that must start again from the count byte. Directed transactions drive both cases: an eight-byte write, and a two-byte read that ends early followed by a full read. Random writes of random length and content, each followed by a full read-back, then cover partial updates against a register model kept in the bench.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_ACK_HOLD,
    ST_TX,
    ST_TX_ACK,
    ST_TX_ACKW,
    ST_TX_NEXT
  } cfgw_state_t;

  localparam int unsigned HDR_BYTES = 3;  // address, command, count
endpackage

// File: rtl/cfgw_line_sync.sv
module cfgw_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic scl_p, sda_p;
  logic scl_s;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else if (g == 0) begin
          scl_ff[g] <= scl_in;
          sda_ff[g] <= sda_in;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/cfgw_regbank.sv
module cfgw_regbank #(
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned DW = 8,
  parameter int unsigned IDX_W = 4,
  parameter logic [NUM_REGS*DW-1:0] RESET_VALUE = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [IDX_W-1:0]       waddr,
  input  logic [DW-1:0]          wdata,
  input  logic [IDX_W-1:0]       rsel,
  output logic [DW-1:0]          rdata,
  output logic [NUM_REGS*DW-1:0] cfg_flat
);
  logic [DW-1:0] regs [NUM_REGS];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)
          regs[g] <= RESET_VALUE[g*DW +: DW];
        else if (we && (waddr == IDX_W'(g)))
          regs[g] <= wdata;
      end
      assign cfg_flat[g*DW +: DW] = regs[g];
    end
  endgenerate

  // rsel 0 selects the count byte, rsel k selects register k-1
  always_comb begin
    rdata = '1;
    if (rsel == '0)
      rdata = DW'(NUM_REGS);
    else
      for (int i = 0; i < NUM_REGS; i++)
        if (rsel == IDX_W'(i + 1)) rdata = regs[i];
  end
endmodule

// File: rtl/cfgw_link_fsm.sv
module cfgw_link_fsm
  import cfgw_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned IDX_W = 4,
  parameter logic [6:0]  DEV_ADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             we,
  output logic [IDX_W-1:0] waddr,
  output logic [DW-1:0]    wdata,
  output logic [IDX_W-1:0] rsel,
  input  logic [DW-1:0]    rdata,
  output logic             sda_oe
);
  localparam int unsigned BC_W = $clog2(DW + 1);
  localparam logic [IDX_W-1:0] IDX_MAX  = '1;
  localparam logic [IDX_W-1:0] DATA_LO  = IDX_W'(HDR_BYTES);
  localparam logic [IDX_W-1:0] DATA_END = IDX_W'(HDR_BYTES + NUM_REGS);
  localparam logic [BC_W-1:0]  LAST_BIT = BC_W'(DW - 1);

  cfgw_state_t      state;
  logic [BC_W-1:0]  bitcnt;
  logic [DW-1:0]    shreg;
  logic [DW-1:0]    txsh;
  logic [IDX_W-1:0] idx;
  logic             is_read;
  logic             ack_q;
  logic [DW-1:0]    rx_byte;
  logic             byte_done;

  assign rx_byte   = {shreg[DW-2:0], sda_s};
  assign byte_done = (state == ST_RX) && scl_rise && (bitcnt == LAST_BIT);

  assign we    = byte_done && (idx >= DATA_LO) && (idx < DATA_END);
  assign waddr = idx - DATA_LO;
  assign wdata = rx_byte;
  assign rsel  = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      txsh    <= '0;
      idx     <= '0;
      is_read <= 1'b0;
      ack_q   <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      state   <= ST_RX;
      bitcnt  <= '0;
      idx     <= '0;
      is_read <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise) begin
            shreg <= rx_byte;
            if (bitcnt == LAST_BIT) begin
              bitcnt <= '0;
              state  <= ST_RX_ACK;
              if (idx == '0) begin
                ack_q   <= (rx_byte[DW-1:1] == DEV_ADDR);
                is_read <= rx_byte[0];
                idx     <= rx_byte[0] ? '0 : IDX_W'(1);
              end else begin
                ack_q <= (idx < DATA_END);
                if (idx != IDX_MAX) idx <= idx + 1'b1;
              end
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            sda_oe <= ack_q;
            state  <= ST_ACK_HOLD;
          end
        end
        ST_ACK_HOLD: begin
          if (scl_fall) begin
            if (!ack_q) begin
              sda_oe <= 1'b0;
              state  <= ST_IDLE;
            end else if (is_read) begin
              sda_oe <= ~rdata[DW-1];
              txsh   <= rdata << 1;
              bitcnt <= '0;
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            sda_oe <= ~txsh[DW-1];
            txsh   <= txsh << 1;
          end else if (scl_rise) begin
            if (bitcnt == LAST_BIT) begin
              bitcnt <= '0;
              state  <= ST_TX_ACK;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_TX_ACKW;
          end
        end
        ST_TX_ACKW: begin
          if (scl_rise) begin
            if (!sda_s) begin
              if (idx != IDX_MAX) idx <= idx + 1'b1;
              state <= ST_TX_NEXT;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_TX_NEXT: begin
          if (scl_fall) begin
            sda_oe <= ~rdata[DW-1];
            txsh   <= rdata << 1;
            bitcnt <= '0;
            state  <= ST_TX;
          end
        end
        default: begin
          sda_oe <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cfg_twowire_slave.sv
module cfg_twowire_slave #(
  parameter int unsigned NUM_REGS    = 7,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter logic [NUM_REGS*DW-1:0] RESET_VALUE = 56'h06_00_00_00_F0_FC_00
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl_in,
  input  logic                   sda_in,
  output logic                   sda_oe,
  output logic [NUM_REGS*DW-1:0] cfg_bytes
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS + 4);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             we;
  logic [IDX_W-1:0] waddr, rsel;
  logic [DW-1:0]    wdata, rdata;

  cfgw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cfgw_link_fsm #(
    .DW(DW), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .DEV_ADDR(DEV_ADDR)
  ) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .we(we), .waddr(waddr), .wdata(wdata), .rsel(rsel), .rdata(rdata),
    .sda_oe(sda_oe)
  );

  cfgw_regbank #(
    .NUM_REGS(NUM_REGS), .DW(DW), .IDX_W(IDX_W), .RESET_VALUE(RESET_VALUE)
  ) u_bank (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .rsel(rsel), .rdata(rdata), .cfg_flat(cfg_bytes)
  );
endmodule

// File: rtl/cfgw_checker.sv
module cfgw_checker #(
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned DW = 8,
  parameter logic [NUM_REGS*DW-1:0] RESET_VALUE = '0
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   scl_in,
  input logic                   sda_oe,
  input logic [NUM_REGS*DW-1:0] cfg_bytes
);
  logic [NUM_REGS*DW-1:0] cfg_prev;
  logic [NUM_REGS-1:0]    chg_mask;

  always_ff @(posedge clk) cfg_prev <= cfg_bytes;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
      assign chg_mask[g] = (cfg_prev[g*DW +: DW] != cfg_bytes[g*DW +: DW]);
    end
  endgenerate

  a_r1_reset_defaults: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_bytes == RESET_VALUE));

  a_r9_drive_while_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_in);

  a_r4_one_byte_per_cycle: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(chg_mask) <= 1));

  a_r4_store_while_high: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (chg_mask != '0)) |-> scl_in);
endmodule

bind cfg_twowire_slave cfgw_checker #(
  .NUM_REGS(NUM_REGS), .DW(DW), .RESET_VALUE(RESET_VALUE)
) u_chk (
  .clk(clk), .rst(rst), .scl_in(scl_in), .sda_oe(sda_oe), .cfg_bytes(cfg_bytes)
);

// File: tb/sim_cfg_twowire_slave.sv
module sim_cfg_twowire_slave;
  localparam int Q = 10;
  localparam int NR = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic host_low = 1'b0;
  logic sda_oe;
  logic [NR*8-1:0] cfg_bytes;
  logic sda_line;

  int total = 0;
  int bad = 0;
  int r9_viol = 0;
  logic oe_prev = 1'b0;
  logic [7:0] model [NR];

  always #2 clk = ~clk;

  assign sda_line = !(host_low || sda_oe);

  cfg_twowire_slave u0 (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .cfg_bytes(cfg_bytes)
  );

  always @(posedge clk) begin
    oe_prev <= sda_oe;
    if (!rst && sda_oe && !oe_prev && scl) r9_viol <= r9_viol + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NR*8-1:0] model_flat();
    logic [NR*8-1:0] v;
    for (int i = 0; i < NR; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic bus_start();
    host_low = 1'b0; scl = 1'b1; tick(Q);
    host_low = 1'b1; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    scl = 1'b0; host_low = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    host_low = 1'b0; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      host_low = !b[i]; tick(Q);
      scl = 1'b1; tick(2*Q);
      scl = 1'b0; tick(Q);
    end
    host_low = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    acked = !sda_line;
    tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    host_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl = 1'b0; tick(Q);
    end
    host_low = give_ack;
    tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
    host_low = 1'b0;
  endtask

  // Write n data bytes; expects ack for bytes inside the bank, stops at first NACK.
  task automatic do_write(input int n, input logic [7:0] d [10], input string req);
    bit a;
    bus_start();
    send_byte(8'hD2, a);
    check(a, "R2 write address ack", a, 1);
    send_byte(8'h5A, a);
    check(a, "R3 command byte ack", a, 1);
    send_byte(8'h33, a);
    check(a, "R3 count byte ack", a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a);
      if (i < NR) begin
        check(a, req, a, 1);
        model[i] = d[i];
      end else begin
        check(!a, "R6 byte past bank not acked", a, 0);
        break;
      end
    end
    bus_stop();
    check(cfg_bytes == model_flat(), req, cfg_bytes, model_flat());
  endtask

  task automatic do_read(input int n);
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, a);
    check(a, "R2 read address ack", a, 1);
    recv_byte(1'b1, b);
    check(b == 8'd7, "R7 count byte", b, 7);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      check(b == model[i], "R7 read data", b, model[i]);
    end
    tick(2);
    check(!sda_oe, "R10 released after host nack", sda_oe, 0);
    bus_stop();
  endtask

  initial begin : main
    logic [7:0] d [10];
    bit a;
    int n;
    void'($urandom(32'd20240611));
    model[0] = 8'h00; model[1] = 8'hFC; model[2] = 8'hF0; model[3] = 8'h00;
    model[4] = 8'h00; model[5] = 8'h00; model[6] = 8'h06;
    tick(5);
    rst = 1'b0;
    tick(3);
    check(cfg_bytes == model_flat(), "R1 reset defaults", cfg_bytes, model_flat());
    check(!sda_oe, "R1 sda_oe idle", sda_oe, 0);

    do_read(NR);

    // R2: foreign address, then try to write data anyway
    bus_start();
    send_byte(8'hA4, a);
    check(!a, "R2 foreign address not acked", a, 0);
    send_byte(8'h00, a);
    check(!a, "R2 silent after foreign address", a, 0);
    bus_stop();
    check(cfg_bytes == model_flat(), "R2 bank untouched", cfg_bytes, model_flat());

    // R3: header only
    do_write(0, d, "R3 header bytes discarded");

    // R4: full write
    for (int i = 0; i < 10; i++) d[i] = 8'h11 * (i + 1);
    do_write(NR, d, "R4 ordered data store");

    // R5: partial write
    d[0] = 8'hA0; d[1] = 8'hB1; d[2] = 8'hC2;
    do_write(3, d, "R5 partial write keeps rest");

    // R6: overflow
    for (int i = 0; i < 10; i++) d[i] = 8'h40 + 8'(i);
    do_write(NR + 1, d, "R6 overflow write");

    // R8/R10: short read then full read starts at count again
    do_read(2);
    do_read(NR);
    check(1'b1, "R8 read restart", 0, 0);

    for (int k = 0; k < 6; k++) begin
      n = $urandom_range(0, NR);
      for (int i = 0; i < 10; i++) d[i] = 8'($urandom);
      do_write(n, d, "R5 random partial write");
      do_read(NR);
    end

    check(r9_viol == 0, "R9 drive only while scl low", r9_viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule